// File: doc/BRIEF.md
# Programmable Byte-Serial Master Shifter

This block is the shifting core of a byte-wide serial peripheral interface master. It is meant to sit behind a small register file. Writing a byte into the transmit side of the data buffer starts an eight-bit exchange at once. The block then drives the serial clock and the serial data output, and it captures the serial data input. When the last bit has been captured, the received byte replaces the readable buffer contents and a sticky interrupt flag rises.

Four settings shape each exchange: the resting level of the serial clock, where in each bit the output data changes, the point at which the input is captured, and the bit-rate source. The bit rate comes from one of three fixed divisions of the system clock, a programmable reload divider, or half the rate of an external timer pulse. The block samples these settings only while it is idle, so a transfer keeps the settings it started with. For receive-only use, the data output can be held low while the input is still shifted at the normal rate.

Each bit period consists of two half periods. In every mode but the timer mode, a half period has a fixed length counted in system clocks. In timer mode, a half period ends on each timer pulse.

Top module: `spi_master_engine`

## Requirements
- R1: A buf_wr pulse while busy is low loads buf_wdata. busy is high from the next clock until the exchange completes, and it stays high for exactly 16 half periods.
- R2: Data leaves msb first. Bit k (k = 0 for the msb) is on sdo for half periods 2k and 2k+1. With cfg_cke = 1, sck is at rest in half period 2k and active in 2k+1. With cfg_cke = 0, sck is active in half period 2k and at rest in 2k+1.
- R3: When idle, sck equals the latched cfg_cpol. The active level is its inverse.
- R4: With cfg_smp = 0, sdi is captured at the end of half period 2k (mid bit). With cfg_smp = 1, it is captured at the end of half period 2k+1 (end of bit). Captured bits fill the received byte msb first.
- R5: cfg_rate sets the half-period length. 0 gives 2 clocks (bit = clock/4). 1 gives 8 clocks (clock/16). 2 gives 32 clocks (clock/64). 3 ends a half period on each tmr_tick pulse (bit = tick/2). 4 gives 2*(cfg_reload+1) clocks (bit = clock/(4*(reload+1))). Codes 5 to 7 behave as code 0.
- R6: On the clock edge that ends the last half period, the received byte appears on buf_rdata, buf_full and irq rise, and busy falls.
- R7: With cfg_tx_off = 1 latched, sdo stays 0 for the whole exchange. Reception and timing are unchanged.
- R8: A buf_wr while busy is ignored and sets wcol. wcol clears on a wcol_clr pulse. If a collision and wcol_clr occur together, the collision wins.
- R9: irq holds until an irq_clr pulse, and buf_full holds until a buf_rd pulse. If a completion and a clear occur on the same edge, the completion wins.
- R10: The settings (polarity, phase, sample point, tx disable, rate, reload) are latched on every clock while idle and frozen while busy.
- R11: After reset: sck 0, sdo 0, busy 0, buf_full 0, irq 0, wcol 0, buf_rdata 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cpol | input | 1 | Resting level of sck |
| cfg_cke | input | 1 | 1: data valid before the first sck edge of a bit |
| cfg_smp | input | 1 | 1: capture sdi at end of bit, 0: mid bit |
| cfg_tx_off | input | 1 | 1: hold sdo low (receive only) |
| cfg_rate | input | 3 | Bit-rate source select |
| cfg_reload | input | 8 | Reload value for the divider source |
| tmr_tick | input | 1 | One-clock timer pulse, synchronous to clk |
| buf_wr | input | 1 | Write strobe for the transmit byte |
| buf_wdata | input | 8 | Transmit byte |
| buf_rd | input | 1 | Read strobe, clears buf_full |
| irq_clr | input | 1 | Clears irq |
| wcol_clr | input | 1 | Clears wcol |
| sdi | input | 1 | Serial data in |
| buf_rdata | output | 8 | Last received byte |
| buf_full | output | 1 | Received byte not yet read |
| busy | output | 1 | Exchange in progress |
| irq | output | 1 | Sticky completion flag |
| wcol | output | 1 | Write-collision flag |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |

## Verification
The assertions assume that all inputs are synchronous to clk and have known values once reset is released. They also assume that tmr_tick is a pulse one clock wide, so one half period ends for each pulse. The stimulus changes every input just after a falling clock edge. It generates the timer pulse one clock in every three, and it changes settings in the middle of a transfer only to show that the latched copy ignores them. The serial input is given a different value in each half of every bit, so mid-bit and end-of-bit capture produce different received bytes.

// File: rtl/spi_me_pkg.sv
// spi_me_pkg: shared rate codes and the latched mode record for the
// serial master engine. Assumes a 3-bit rate select field.
package spi_me_pkg;
    localparam logic [2:0] RATE_Q4     = 3'd0;
    localparam logic [2:0] RATE_Q16    = 3'd1;
    localparam logic [2:0] RATE_Q64    = 3'd2;
    localparam logic [2:0] RATE_TMR    = 3'd3;
    localparam logic [2:0] RATE_RELOAD = 3'd4;

    typedef struct packed {
        logic       cpol;
        logic       cke;
        logic       smp;
        logic       tx_off;
        logic [2:0] rate;
    } mode_t;
endpackage

// File: rtl/spi_me_baud.sv
// spi_me_baud: produces a one-clock pulse that marks the end of each half
// bit period. It uses a fixed half length, a reload-derived half length or
// the external timer pulse. Assumes rate and reload stay stable while run is high.
module spi_me_baud #(
    parameter int RELOAD_W = 8,
    parameter int HALF_A   = 2,
    parameter int HALF_B   = 8,
    parameter int HALF_C   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [2:0]          rate,
    input  logic [RELOAD_W-1:0] reload,
    input  logic                tmr_tick,
    output logic                hend
);
    import spi_me_pkg::*;

    localparam int CNT_W = RELOAD_W + 2;

    logic [CNT_W-1:0] half_len;
    logic [CNT_W-1:0] cnt_q;
    logic             use_tmr;
    logic             wrap;

    // Select the half-period length from the rate code.
    always_comb begin
        case (rate)
            RATE_Q16:    half_len = CNT_W'(HALF_B);
            RATE_Q64:    half_len = CNT_W'(HALF_C);
            RATE_RELOAD: half_len = {1'b0, reload, 1'b0} + CNT_W'(2);
            default:     half_len = CNT_W'(HALF_A);
        endcase
    end

    assign use_tmr = (rate == RATE_TMR);
    assign wrap    = (cnt_q == half_len - CNT_W'(1));
    assign hend    = run & (use_tmr ? tmr_tick : wrap);

    // Count clocks within a half period; cleared while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (!use_tmr) begin
            cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // R5: the counter never passes the selected half length.
    a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !use_tmr) |-> (cnt_q < half_len));
endmodule

// File: rtl/spi_me_shift.sv
// spi_me_shift: holds the transmit and receive shift registers and the
// half-period index. It forms sck from the index and the latched mode,
// and it flags the completion edge. Assumes start is only raised while idle.
module spi_me_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              hend,
    input  logic              cpol,
    input  logic              cke,
    input  logic              smp,
    input  logic              tx_off,
    input  logic              sdi,
    output logic              busy,
    output logic              sck,
    output logic              sdo,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);
    localparam int SLOTS  = 2 * DATA_W;
    localparam int SLOT_W = $clog2(SLOTS);

    logic              busy_q;
    logic [SLOT_W-1:0] slot_q;
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic [DATA_W-1:0] rx_shifted;
    logic              sample;
    logic              last;

    assign sample     = hend & (slot_q[0] == smp);
    assign last       = (slot_q == SLOT_W'(SLOTS - 1));
    assign done       = hend & last;
    assign rx_shifted = {rx_q[DATA_W-2:0], sdi};
    assign rx_word    = sample ? rx_shifted : rx_q;

    // Load on start; on each half end, capture, shift and advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            slot_q <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            slot_q <= '0;
            tx_q   <= tx_data;
            rx_q   <= '0;
        end else if (hend) begin
            if (sample) begin
                rx_q <= rx_shifted;
            end
            if (slot_q[0]) begin
                tx_q <= {tx_q[DATA_W-2:0], 1'b0};
            end
            slot_q <= slot_q + SLOT_W'(1);
            if (last) begin
                busy_q <= 1'b0;
            end
        end
    end

    // Serial clock: resting level when idle, phase chosen by cke when busy.
    always_comb begin
        if (busy_q) begin
            sck = cpol ^ (slot_q[0] == cke);
        end else begin
            sck = cpol;
        end
    end

    assign busy = busy_q;
    assign sdo  = busy_q & ~tx_off & tx_q[DATA_W-1];

    // R2: output data only moves at a half-period end.
    a_r2_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !hend) |=> $stable(tx_q));
    // R6: the completion edge leaves the engine idle.
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy_q);
endmodule

// File: rtl/spi_me_status.sv
// spi_me_status: holds the received-byte buffer and the three sticky flags.
// A set on the same edge as a clear takes priority. Assumes done is a
// one-clock pulse.
module spi_me_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              rd,
    input  logic              irq_clr,
    input  logic              collide,
    input  logic              wcol_clr,
    output logic [DATA_W-1:0] rdata,
    output logic              full,
    output logic              irq,
    output logic              wcol
);
    // Buffer update and flag set/clear with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            full  <= 1'b0;
            irq   <= 1'b0;
            wcol  <= 1'b0;
        end else begin
            if (done) begin
                rdata <= rx_word;
                full  <= 1'b1;
                irq   <= 1'b1;
            end else begin
                if (rd)      full <= 1'b0;
                if (irq_clr) irq  <= 1'b0;
            end
            if (collide) begin
                wcol <= 1'b1;
            end else if (wcol_clr) begin
                wcol <= 1'b0;
            end
        end
    end

    // R6: completion publishes the byte and raises both flags.
    a_r6_publish: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (irq && full && rdata == $past(rx_word)));
    // R8: a collision always leaves wcol set.
    a_r8_wcol_set: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> wcol);
    // R9: irq holds without a clear.
    a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);
endmodule

// File: rtl/spi_master_engine.sv
// spi_master_engine: byte-wide serial master. It latches the mode while
// idle, starts on a buffer write, and reports completion through the
// status flags. Assumes every input is synchronous to clk.
module spi_master_engine #(
    parameter int DATA_W   = 8,
    parameter int RELOAD_W = 8,
    parameter int HALF_A   = 2,
    parameter int HALF_B   = 8,
    parameter int HALF_C   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_cpol,
    input  logic                cfg_cke,
    input  logic                cfg_smp,
    input  logic                cfg_tx_off,
    input  logic [2:0]          cfg_rate,
    input  logic [RELOAD_W-1:0] cfg_reload,
    input  logic                tmr_tick,
    input  logic                buf_wr,
    input  logic [DATA_W-1:0]   buf_wdata,
    input  logic                buf_rd,
    input  logic                irq_clr,
    input  logic                wcol_clr,
    input  logic                sdi,
    output logic [DATA_W-1:0]   buf_rdata,
    output logic                buf_full,
    output logic                busy,
    output logic                irq,
    output logic                wcol,
    output logic                sck,
    output logic                sdo
);
    import spi_me_pkg::*;

    mode_t               mode_q;
    logic [RELOAD_W-1:0] reload_q;
    logic                hend;
    logic                start;
    logic                collide;
    logic                done;
    logic [DATA_W-1:0]   rx_word;

    assign start   = buf_wr & ~busy;
    assign collide = buf_wr & busy;

    // Track the settings while idle; hold them during an exchange.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            reload_q <= '0;
        end else if (!busy) begin
            mode_q   <= '{cpol: cfg_cpol, cke: cfg_cke, smp: cfg_smp,
                          tx_off: cfg_tx_off, rate: cfg_rate};
            reload_q <= cfg_reload;
        end
    end

    spi_me_baud #(
        .RELOAD_W (RELOAD_W),
        .HALF_A   (HALF_A),
        .HALF_B   (HALF_B),
        .HALF_C   (HALF_C)
    ) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .rate     (mode_q.rate),
        .reload   (reload_q),
        .tmr_tick (tmr_tick),
        .hend     (hend)
    );

    spi_me_shift #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tx_data (buf_wdata),
        .hend    (hend),
        .cpol    (mode_q.cpol),
        .cke     (mode_q.cke),
        .smp     (mode_q.smp),
        .tx_off  (mode_q.tx_off),
        .sdi     (sdi),
        .busy    (busy),
        .sck     (sck),
        .sdo     (sdo),
        .done    (done),
        .rx_word (rx_word)
    );

    spi_me_status #(
        .DATA_W (DATA_W)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (done),
        .rx_word  (rx_word),
        .rd       (buf_rd),
        .irq_clr  (irq_clr),
        .collide  (collide),
        .wcol_clr (wcol_clr),
        .rdata    (buf_rdata),
        .full     (buf_full),
        .irq      (irq),
        .wcol     (wcol)
    );

    // R1: an idle write starts an exchange on the next clock.
    a_r1_start: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && !busy) |=> busy);
    // R10: the latched settings do not move while busy.
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(mode_q) && $stable(reload_q)));
endmodule

// File: tb/spi_master_engine_bench.sv
`timescale 1ns/1ps
// spi_master_engine_bench: runs a behavioural reference model alongside
// the design and compares every output on every falling clock edge.
module spi_master_engine_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_cpol = 1'b0, cfg_cke = 1'b0, cfg_smp = 1'b0, cfg_tx_off = 1'b0;
    logic [2:0] cfg_rate = 3'd0;
    logic [7:0] cfg_reload = 8'd0;
    logic       tmr_tick = 1'b0;
    logic       buf_wr = 1'b0;
    logic [7:0] buf_wdata = 8'd0;
    logic       buf_rd = 1'b0, irq_clr = 1'b0, wcol_clr = 1'b0, sdi = 1'b0;
    logic [7:0] buf_rdata;
    logic       buf_full, busy, irq, wcol, sck, sdo;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    int tick_cnt = 0;
    bit tick_en = 0;
    logic [7:0] sl_a = 8'h00, sl_b = 8'h00;

    // reference model state
    bit m_busy, m_full, m_irq, m_wcol;
    bit m_cpol, m_cke, m_smp, m_txoff;
    int m_rate, m_rel, m_t;
    logic [7:0] m_tx, m_rx, m_buf;

    always #10 clk = ~clk;

    spi_master_engine u_spi_master_engine (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cke(cfg_cke),
        .cfg_smp(cfg_smp), .cfg_tx_off(cfg_tx_off), .cfg_rate(cfg_rate),
        .cfg_reload(cfg_reload), .tmr_tick(tmr_tick), .buf_wr(buf_wr),
        .buf_wdata(buf_wdata), .buf_rd(buf_rd), .irq_clr(irq_clr),
        .wcol_clr(wcol_clr), .sdi(sdi), .buf_rdata(buf_rdata),
        .buf_full(buf_full), .busy(busy), .irq(irq), .wcol(wcol),
        .sck(sck), .sdo(sdo)
    );

    function automatic int half_of(int r, int rel);
        if (r == 1) return 8;
        if (r == 2) return 32;
        if (r == 4) return 2 * (rel + 1);
        return 2;
    endfunction

    function automatic int slot_now();
        if (m_rate == 3) return m_t;
        return m_t / half_of(m_rate, m_rel);
    endfunction

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model: advance on each rising edge from the stable inputs.
    always @(posedge clk) begin
        bit busy_pre, fin;
        int h, s;
        bit eos;
        if (!rst_n) begin
            m_busy = 0; m_full = 0; m_irq = 0; m_wcol = 0;
            m_cpol = 0; m_cke = 0; m_smp = 0; m_txoff = 0;
            m_rate = 0; m_rel = 0; m_t = 0;
            m_tx = 0; m_rx = 0; m_buf = 0;
        end else begin
            busy_pre = m_busy;
            fin = 0;
            if (!busy_pre) begin
                m_cpol = cfg_cpol; m_cke = cfg_cke; m_smp = cfg_smp;
                m_txoff = cfg_tx_off; m_rate = int'(cfg_rate); m_rel = int'(cfg_reload);
            end
            if (busy_pre && (m_rate != 3 || tmr_tick)) begin
                h = half_of(m_rate, m_rel);
                s = slot_now();
                eos = (m_rate == 3) ? 1'b1 : ((m_t % h) == h - 1);
                if (eos) begin
                    if ((s % 2 == 1) == m_smp) m_rx = {m_rx[6:0], sdi};
                    if (s == 15) begin fin = 1; m_busy = 0; end
                end
                m_t++;
            end
            if (fin) begin
                m_buf = m_rx; m_full = 1; m_irq = 1;
            end else begin
                if (buf_rd) m_full = 0;
                if (irq_clr) m_irq = 0;
            end
            if (buf_wr && busy_pre) m_wcol = 1;
            else if (wcol_clr) m_wcol = 0;
            if (buf_wr && !busy_pre) begin
                m_busy = 1; m_t = 0; m_tx = buf_wdata; m_rx = 0;
            end
        end
    end

    // Compare on every falling edge, then drive sdi, tick and the watchdog.
    always @(negedge clk) begin
        int s;
        int exp_sck, exp_sdo;
        cyc++;
        if (rst_n) begin
            s = slot_now();
            exp_sck = m_busy ? int'(m_cpol ^ (s[0] == m_cke)) : int'(m_cpol);
            exp_sdo = (m_busy && !m_txoff) ? int'(m_tx[7 - s / 2]) : 0;
            chk(m_busy ? "R2 sck phase" : "R3 sck rest", sck, exp_sck);
            chk(m_txoff ? "R7 sdo off" : "R2 sdo bit", sdo, exp_sdo);
            chk("R1 busy", busy, m_busy);
            chk("R4 rx byte", buf_rdata, m_buf);
            chk("R6 full", buf_full, m_full);
            chk("R9 irq", irq, m_irq);
            chk("R8 wcol", wcol, m_wcol);
            if (m_busy) begin
                s = slot_now();
                sdi <= s[0] ? sl_b[7 - s / 2] : sl_a[7 - s / 2];
            end else begin
                sdi <= 1'b0;
            end
        end
        if (tick_en) begin
            tick_cnt++;
            tmr_tick <= (tick_cnt % 3 == 0);
        end else begin
            tmr_tick <= 1'b0;
        end
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // One exchange; poke 1 = write while busy, poke 2 = change settings mid-way.
    task automatic xfer(input logic [7:0] data, input logic [7:0] a,
                        input logic [7:0] b, input int exp_rx,
                        input int exp_len, input int poke);
        int len;
        sl_a = a; sl_b = b;
        @(negedge clk); buf_wr <= 1'b1; buf_wdata <= data;
        @(negedge clk); buf_wr <= 1'b0;
        len = 0;
        while (busy) begin
            len++;
            if (len == 5 && poke == 1) begin buf_wr <= 1'b1; buf_wdata <= 8'hFF; end
            if (len == 5 && poke == 2) begin
                cfg_smp <= ~cfg_smp; cfg_cpol <= ~cfg_cpol; cfg_rate <= 3'd2;
            end
            if (len == 6) buf_wr <= 1'b0;
            @(negedge clk);
        end
        chk(poke == 2 ? "R10 frozen settings" : "R4 rx capture", buf_rdata, exp_rx);
        if (exp_len > 0) chk("R5 exchange length", len, exp_len);
        @(negedge clk);
    endtask

    task automatic mode(input bit p, input bit e, input bit sm, input bit off,
                        input logic [2:0] r, input logic [7:0] rl);
        cfg_cpol <= p; cfg_cke <= e; cfg_smp <= sm; cfg_tx_off <= off;
        cfg_rate <= r; cfg_reload <= rl;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n <= 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 sck", sck, 0);
        chk("R11 busy", busy, 0);
        chk("R11 irq", irq, 0);
        chk("R11 rdata", buf_rdata, 0);
        chk("R11 sdo", sdo, 0);

        mode(0, 1, 0, 0, 3'd0, 8'd0);
        xfer(8'hA5, 8'h3C, 8'hC3, 8'h3C, 32, 0);      // R5 clock/4, mid capture
        mode(1, 0, 1, 0, 3'd1, 8'd0);
        xfer(8'h5A, 8'h96, 8'h69, 8'h69, 128, 0);     // R5 clock/16, end capture
        mode(0, 0, 0, 0, 3'd2, 8'd0);
        xfer(8'hF0, 8'h81, 8'h7E, 8'h81, 512, 0);     // R5 clock/64
        tick_en = 1;
        mode(1, 1, 1, 0, 3'd3, 8'd0);
        xfer(8'h0F, 8'h12, 8'hED, 8'hED, 0, 0);       // R5 timer tick source
        tick_en = 0;
        mode(0, 1, 0, 0, 3'd4, 8'd0);
        xfer(8'h33, 8'hAA, 8'h55, 8'hAA, 32, 0);      // R5 reload 0
        mode(1, 1, 1, 0, 3'd4, 8'd5);
        xfer(8'hCC, 8'h0F, 8'hF0, 8'hF0, 192, 0);     // R5 reload 5
        mode(0, 0, 0, 0, 3'd6, 8'd9);
        xfer(8'h99, 8'hE1, 8'h1E, 8'hE1, 32, 0);      // R5 reserved code
        mode(0, 1, 0, 1, 3'd0, 8'd0);
        xfer(8'hFF, 8'h6B, 8'h94, 8'h6B, 32, 0);      // R7 transmit disabled
        chk("R7 sdo low after", sdo, 0);
        mode(0, 1, 0, 0, 3'd0, 8'd0);
        xfer(8'h3A, 8'hB4, 8'h4B, 8'hB4, 32, 1);      // R8 collision
        chk("R8 wcol set", wcol, 1);
        wcol_clr <= 1'b1; @(negedge clk); wcol_clr <= 1'b0; @(negedge clk);
        chk("R8 wcol cleared", wcol, 0);
        mode(0, 1, 0, 0, 3'd1, 8'd0);
        xfer(8'h77, 8'hC6, 8'h39, 8'hC6, 128, 2);     // R10 mid-way changes
        mode(0, 1, 1, 0, 3'd0, 8'd0);
        irq_clr <= 1'b1; buf_rd <= 1'b1;
        xfer(8'h21, 8'h5D, 8'hA2, 8'hA2, 32, 0);      // R9 set beats clear
        irq_clr <= 1'b0; buf_rd <= 1'b0;
        @(negedge clk);
        irq_clr <= 1'b1; @(negedge clk); irq_clr <= 1'b0; @(negedge clk);
        chk("R9 irq cleared", irq, 0);
        buf_rd <= 1'b1; @(negedge clk); buf_rd <= 1'b0; @(negedge clk);
        chk("R9 full cleared", buf_full, 0);
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule